// File: doc/BRIEF.md
# Multiplexed Seven-Segment Readout Driver

This block turns a latched four-digit BCD reading, a polarity bit and an overrange flag into the drive signals for a time-multiplexed, four-position seven-segment display of the kind used on a meter with a 0 to 3999 count range. It lights one digit position at a time, stepping from the most significant position down to the least significant one, and holds each position for a fixed number of input clocks. At the start of every position it keeps all enables and segments dark for a short gap, so that the display never shows a mix of the previous and next digits.

The digit values, polarity and overrange flag are sampled once, at the first clock of each digit slot. The lit part of a slot therefore cannot change partway through. A zero in the leading position is shown dark. When the overrange flag is set, the number is replaced by a fixed pattern: the letters O, F and L in the three lower positions, and a minus bar or nothing in the leading position, depending on polarity. The polarity and overrange flags are also brought out on their own pins. All outputs are registered.

Top module: `mux7_readout`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is 0 after that edge, and the phase and slot counters return to the start of the leading slot.
- R2: Number the rising edges after reset release from 1. The outputs after edge n show slot s = ((n-1)/512) mod 4 at phase p = (n-1) mod 512. Slot 0 is the most significant digit and slot 3 the least significant. During the lit part of slot s, `digit_en` is 4'b1000 shifted right by s.
- R3: For phases 0 to 15 of every slot (1/32 of the 512-clock slot), `digit_en` and `seg_out` are all zero.
- R4: `digit_en` never has more than one bit set.
- R5: Segments are active high, with bit 0 = a through bit 6 = g. The digits 0 to 9 give 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F. Nibble [15:12] of `bcd_in` is the leading digit and [3:0] is the last.
- R6: When the sampled leading digit is 0 and there is no overrange, the leading slot keeps its enable but shows 0x00. A zero in any other position shows 0x3F.
- R7: When the sampled overrange flag is 1, slots 1, 2 and 3 show O (0x3F), F (0x71) and L (0x38). Slot 0 shows 0x40 if the sampled polarity is negative and 0x00 if it is positive. `overrange_out` equals the sampled flag.
- R8: `sign_out` equals the sampled polarity: 1 for positive, 0 for negative.
- R9: `bcd_in`, `positive_in` and `overrange_in` are sampled only at the edge where phase p = 0. The outputs after edges n ≥ 2 of a slot use that sample, so a change to an input during a slot has no effect until the next slot.
- R10: A nibble above 9 in any position shows 0x00 when there is no overrange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also sets the scan rate |
| rst | input | 1 | Synchronous active-high reset |
| bcd_in | input | 16 | Four BCD digits, most significant in [15:12] |
| positive_in | input | 1 | Polarity of the reading, 1 = positive |
| overrange_in | input | 1 | Reading exceeds the display range |
| seg_out | output | 7 | Segments a..g in bits 0..6, active high |
| digit_en | output | 4 | One-hot digit enable, bit 3 = leading position |
| sign_out | output | 1 | Registered polarity, 1 = positive |
| overrange_out | output | 1 | Registered overrange flag |

## Verification
The bench changes the reading and the flags in the middle of a lit slot. A design that samples its inputs continuously would switch segments while the enable is on, and the display would ghost. The bench also covers a zero leading digit, zeros in the lower positions, nibbles that are not decimal, and both polarities of overrange. A design that got these wrong would blank the wrong digit, drop the enable of a blanked position, or show a stray minus bar on a positive overflow. A reset in the middle of a scan, followed by a count of the cycles from reset to the first lit leading digit and to each following gap, exposes an off-by-one in the gap length or the slot length, or a scan that restarts at the wrong position.

// File: rtl/mux7_pkg.sv
package mux7_pkg;

  localparam int SEG_W = 7;
  localparam int NIB_W = 4;

  typedef logic [SEG_W-1:0] seg_t;

  typedef struct packed {
    logic positive;
    logic over;
  } flags_t;

  localparam seg_t GLYPH_DARK  = 7'h00;
  localparam seg_t GLYPH_MINUS = 7'h40;
  localparam seg_t GLYPH_O     = 7'h3F;
  localparam seg_t GLYPH_F     = 7'h71;
  localparam seg_t GLYPH_L     = 7'h38;

  // bit 0 = segment a ... bit 6 = segment g
  function automatic seg_t bcd_glyph(input logic [NIB_W-1:0] d);
    seg_t g;
    case (d)
      4'd0: g = 7'h3F;
      4'd1: g = 7'h06;
      4'd2: g = 7'h5B;
      4'd3: g = 7'h4F;
      4'd4: g = 7'h66;
      4'd5: g = 7'h6D;
      4'd6: g = 7'h7D;
      4'd7: g = 7'h07;
      4'd8: g = 7'h7F;
      4'd9: g = 7'h6F;
      default: g = GLYPH_DARK;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/mux7_scan_timer.sv
module mux7_scan_timer #(
  parameter int SLOT_CLKS  = 512,
  parameter int GAP_CLKS   = 16,
  parameter int NUM_DIGITS = 4,
  localparam int PH_W = $clog2(SLOT_CLKS),
  localparam int SL_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  output logic [SL_W-1:0] slot,
  output logic            slot_start,
  output logic            in_gap
);

  logic [PH_W-1:0] phase;
  logic            phase_last;
  logic            slot_last;

  assign phase_last = (phase == PH_W'(SLOT_CLKS - 1));
  assign slot_last  = (slot == SL_W'(NUM_DIGITS - 1));
  assign slot_start = (phase == '0);
  assign in_gap     = (phase < PH_W'(GAP_CLKS));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      slot  <= '0;
    end else begin
      phase <= phase_last ? '0 : phase + 1'b1;
      if (phase_last) begin
        slot <= slot_last ? '0 : slot + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mux7_frame_latch.sv
module mux7_frame_latch
  import mux7_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] digits_in,
  input  flags_t            flags_in,
  output logic [DATA_W-1:0] digits_q,
  output flags_t            flags_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      digits_q <= '0;
      flags_q  <= '0;
    end else if (capture) begin
      digits_q <= digits_in;
      flags_q  <= flags_in;
    end
  end

endmodule

// File: rtl/mux7_glyph_select.sv
module mux7_glyph_select
  import mux7_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  localparam int DATA_W = NUM_DIGITS * NIB_W,
  localparam int SL_W   = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic [DATA_W-1:0] digits,
  input  flags_t            flags,
  input  logic [SL_W-1:0]   slot,
  output seg_t              glyph
);

  seg_t glyph_arr [NUM_DIGITS];

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_pos
    logic [NIB_W-1:0] d;
    seg_t             over_g;
    seg_t             norm_g;

    assign d = digits[(NUM_DIGITS-1-i)*NIB_W +: NIB_W];

    if (i == 0) begin : g_lead
      assign over_g = flags.positive ? GLYPH_DARK : GLYPH_MINUS;
      assign norm_g = (d == '0) ? GLYPH_DARK : bcd_glyph(d);
    end else begin : g_rest
      if (i == NUM_DIGITS - 3) begin : g_o
        assign over_g = GLYPH_O;
      end else if (i == NUM_DIGITS - 2) begin : g_f
        assign over_g = GLYPH_F;
      end else if (i == NUM_DIGITS - 1) begin : g_l
        assign over_g = GLYPH_L;
      end else begin : g_blank
        assign over_g = GLYPH_DARK;
      end
      assign norm_g = bcd_glyph(d);
    end

    assign glyph_arr[i] = flags.over ? over_g : norm_g;
  end

  assign glyph = glyph_arr[slot];

endmodule

// File: rtl/mux7_readout.sv
module mux7_readout
  import mux7_pkg::*;
#(
  parameter int SLOT_CLKS  = 512,
  parameter int GAP_DIV    = 32,
  parameter int NUM_DIGITS = 4,
  localparam int GAP_CLKS = SLOT_CLKS / GAP_DIV,
  localparam int DATA_W   = NUM_DIGITS * NIB_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DATA_W-1:0]     bcd_in,
  input  logic                  positive_in,
  input  logic                  overrange_in,
  output logic [SEG_W-1:0]      seg_out,
  output logic [NUM_DIGITS-1:0] digit_en,
  output logic                  sign_out,
  output logic                  overrange_out
);

  localparam int SL_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
  localparam logic [NUM_DIGITS-1:0] EN_LEAD = NUM_DIGITS'(1) << (NUM_DIGITS - 1);

  logic [SL_W-1:0]   slot;
  logic              slot_start;
  logic              in_gap;
  logic [DATA_W-1:0] digits_q;
  flags_t            flags_in;
  flags_t            flags_q;
  seg_t              glyph;

  assign flags_in = '{positive: positive_in, over: overrange_in};

  mux7_scan_timer #(
    .SLOT_CLKS (SLOT_CLKS),
    .GAP_CLKS  (GAP_CLKS),
    .NUM_DIGITS(NUM_DIGITS)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .slot      (slot),
    .slot_start(slot_start),
    .in_gap    (in_gap)
  );

  mux7_frame_latch #(
    .DATA_W(DATA_W)
  ) u_latch (
    .clk      (clk),
    .rst      (rst),
    .capture  (slot_start),
    .digits_in(bcd_in),
    .flags_in (flags_in),
    .digits_q (digits_q),
    .flags_q  (flags_q)
  );

  mux7_glyph_select #(
    .NUM_DIGITS(NUM_DIGITS)
  ) u_select (
    .digits(digits_q),
    .flags (flags_q),
    .slot  (slot),
    .glyph (glyph)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_out       <= '0;
      digit_en      <= '0;
      sign_out      <= 1'b0;
      overrange_out <= 1'b0;
    end else begin
      sign_out      <= flags_q.positive;
      overrange_out <= flags_q.over;
      if (in_gap) begin
        seg_out  <= '0;
        digit_en <= '0;
      end else begin
        seg_out  <= glyph;
        digit_en <= EN_LEAD >> slot;
      end
    end
  end

endmodule

// File: rtl/mux7_readout_chk.sv
module mux7_readout_chk
  import mux7_pkg::*;
#(
  parameter int SLOT_CLKS  = 512,
  parameter int GAP_CLKS   = 16,
  parameter int NUM_DIGITS = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [SEG_W-1:0]      seg_out,
  input logic [NUM_DIGITS-1:0] digit_en,
  input logic                  sign_out,
  input logic                  overrange_out
);

  int   dark_cnt;
  int   lit_cnt;
  logic seen_lit;
  logic seen_dark_after_lit;

  always_ff @(posedge clk) begin
    if (rst) begin
      dark_cnt            <= 0;
      lit_cnt             <= 0;
      seen_lit            <= 1'b0;
      seen_dark_after_lit <= 1'b0;
    end else if (digit_en == '0) begin
      dark_cnt <= dark_cnt + 1;
      lit_cnt  <= 0;
      if (seen_lit) seen_dark_after_lit <= 1'b1;
    end else begin
      dark_cnt <= 0;
      lit_cnt  <= lit_cnt + 1;
      seen_lit <= 1'b1;
    end
  end

  AST_ENABLE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(digit_en)); // R4

  AST_DARK_SEGMENTS: assert property (@(posedge clk) disable iff (rst)
    (digit_en == '0) |-> (seg_out == '0)); // R3

  AST_GAP_LENGTH: assert property (@(posedge clk) disable iff (rst)
    (digit_en != '0 && seen_dark_after_lit && dark_cnt != 0) |-> (dark_cnt == GAP_CLKS)); // R3

  AST_LIT_LENGTH: assert property (@(posedge clk) disable iff (rst)
    (digit_en == '0 && lit_cnt != 0) |-> (lit_cnt == SLOT_CLKS - GAP_CLKS)); // R2

  AST_HOLD_WHILE_LIT: assert property (@(posedge clk) disable iff (rst)
    (digit_en != '0 && $past(digit_en) != '0) |->
      ($stable(seg_out) && $stable(digit_en) && $stable(sign_out) && $stable(overrange_out))); // R9

  AST_OVER_LAST_L: assert property (@(posedge clk) disable iff (rst)
    (overrange_out && digit_en == NUM_DIGITS'(1)) |-> (seg_out == GLYPH_L)); // R7

  AST_OVER_LEAD_POS: assert property (@(posedge clk) disable iff (rst)
    (overrange_out && sign_out && digit_en[NUM_DIGITS-1]) |-> (seg_out == GLYPH_DARK)); // R7

endmodule

bind mux7_readout mux7_readout_chk #(
  .SLOT_CLKS (SLOT_CLKS),
  .GAP_CLKS  (GAP_CLKS),
  .NUM_DIGITS(NUM_DIGITS)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .seg_out      (seg_out),
  .digit_en     (digit_en),
  .sign_out     (sign_out),
  .overrange_out(overrange_out)
);

// File: tb/mux7_readout_bench.sv
module mux7_readout_bench;

  localparam int SLOT  = 512;
  localparam int GAP   = 16;
  localparam int NDIG  = 4;
  localparam int FRAME = SLOT * NDIG;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bcd_in = 16'h0000;
  logic        positive_in = 1'b1;
  logic        overrange_in = 1'b0;
  logic [6:0]  seg_out;
  logic [3:0]  digit_en;
  logic        sign_out;
  logic        overrange_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int wd    = 0;

  // behavioural reference state
  int          cnt = 0;
  logic [15:0] m_bcd = '0;
  bit          m_pos = 1'b0;
  bit          m_ovf = 1'b0;
  logic [6:0]  e_seg = '0;
  logic [3:0]  e_en = '0;
  bit          e_sign = 1'b0;
  bit          e_ovf = 1'b0;
  string       seg_tag = "R1";
  string       en_tag = "R1";
  string       flag_tag_s = "R1";
  string       flag_tag_o = "R1";

  mux7_readout u_mux7_readout (
    .clk          (clk),
    .rst          (rst),
    .bcd_in       (bcd_in),
    .positive_in  (positive_in),
    .overrange_in (overrange_in),
    .seg_out      (seg_out),
    .digit_en     (digit_en),
    .sign_out     (sign_out),
    .overrange_out(overrange_out)
  );

  always #2.5 clk = ~clk;

  function automatic logic [6:0] digit_code(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      cnt = 0; m_bcd = '0; m_pos = 0; m_ovf = 0;
      e_seg = '0; e_en = '0; e_sign = 0; e_ovf = 0;
      seg_tag = "R1"; en_tag = "R1"; flag_tag_s = "R1"; flag_tag_o = "R1";
    end else begin
      int ph;
      int sl;
      int d;
      ph = cnt % SLOT;
      sl = (cnt / SLOT) % NDIG;
      e_sign = m_pos;
      e_ovf  = m_ovf;
      flag_tag_s = "R8";
      flag_tag_o = "R7";
      if (ph < GAP) begin
        e_seg = '0; e_en = '0; seg_tag = "R3"; en_tag = "R3";
      end else begin
        e_en = 4'b1000 >> sl;
        en_tag = "R2";
        d = int'((m_bcd >> ((NDIG - 1 - sl) * 4)) & 16'hF);
        if (m_ovf) begin
          seg_tag = "R7";
          case (sl)
            0: e_seg = m_pos ? 7'h00 : 7'h40;
            1: e_seg = 7'h3F;
            2: e_seg = 7'h71;
            default: e_seg = 7'h38;
          endcase
        end else if (sl == 0 && d == 0) begin
          seg_tag = "R6"; e_seg = 7'h00;
        end else if (d > 9) begin
          seg_tag = "R10"; e_seg = 7'h00;
        end else begin
          seg_tag = (d == 0) ? "R6" : "R5";
          e_seg = digit_code(d);
        end
      end
      if (ph == 0) begin
        m_bcd = bcd_in; m_pos = positive_in; m_ovf = overrange_in;
      end
      cnt = cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(seg_out === e_seg, seg_tag, "seg_out", int'(seg_out), int'(e_seg));
      check(digit_en === e_en, en_tag, "digit_en", int'(digit_en), int'(e_en));
      check(sign_out === e_sign, flag_tag_s, "sign_out", int'(sign_out), int'(e_sign));
      check(overrange_out === e_ovf, flag_tag_o, "overrange_out", int'(overrange_out), int'(e_ovf));
      check($countones(digit_en) <= 1, "R4", "enable count", $countones(digit_en), 1);
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd >= 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion earlier", wd);
      finish_run();
    end
  end

  task automatic drive(input logic [15:0] v, input bit pos, input bit ovf);
    @(negedge clk);
    bcd_in = v; positive_in = pos; overrange_in = ovf;
  endtask

  task automatic run_frames(input int n);
    repeat (n * FRAME) @(negedge clk);
  endtask

  initial begin
    logic [6:0] held_seg;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    drive(16'h1234, 1'b1, 1'b0); run_frames(2);   // R5 R2 R8
    drive(16'h0987, 1'b0, 1'b0); run_frames(2);   // R6 leading zero, R8 negative
    drive(16'h3999, 1'b1, 1'b0); run_frames(1);   // R5 top of range
    drive(16'h0000, 1'b1, 1'b0); run_frames(1);   // R6 zeros in lower positions
    drive(16'h3A5F, 1'b1, 1'b0); run_frames(1);   // R10 non-decimal nibbles
    drive(16'h4000, 1'b1, 1'b1); run_frames(2);   // R7 positive overflow
    drive(16'h4000, 1'b0, 1'b1); run_frames(2);   // R7 negative overflow

    // R9: change everything in the middle of a lit leading slot
    drive(16'h2468, 1'b1, 1'b0); run_frames(1);
    while ((cnt % FRAME) != 200) @(negedge clk);
    held_seg = seg_out;
    bcd_in = 16'h1357; positive_in = 1'b0; overrange_in = 1'b1;
    repeat (100) @(negedge clk);
    check(seg_out === held_seg && digit_en === 4'b1000, "R9", "mid-slot hold",
          int'(seg_out), int'(held_seg));
    check(sign_out === 1'b1, "R9", "sign held mid-slot", int'(sign_out), 1);
    run_frames(1);

    // R1: reset in the middle of a scan, then restart at the leading slot
    drive(16'h3210, 1'b1, 1'b0);
    while ((cnt % SLOT) != 300) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(seg_out === 7'h00 && digit_en === 4'b0000, "R1", "outputs in reset",
          int'({seg_out, digit_en}), 0);
    check(sign_out === 1'b0 && overrange_out === 1'b0, "R1", "flags in reset",
          int'({sign_out, overrange_out}), 0);
    rst = 1'b0;
    repeat (GAP + 1) @(negedge clk);
    check(digit_en === 4'b1000, "R1", "first lit slot after reset", int'(digit_en), 8);
    run_frames(2);

    finish_run();
  end

endmodule